// File: doc/BRIEF.md
# Masked-Repeat Calendar Alarm

This block holds four alarm fields (seconds, minutes, hours and day of month, all BCD) and compares them against the running time of day supplied by an external calendar counter. The comparison is made once per one-second tick. On a match, and when the interrupt is enabled, the block emits a single-cycle interrupt pulse.

Bit 7 of every alarm field is a "don't care" flag. The four flags are decoded as a fixed ladder, and the rung selects which fields take part in the comparison. The rungs give a repeat period of once a month, once a day, once an hour, once a minute or once a second. Writes that carry an out-of-range BCD value are dropped without notice, and the register keeps its old contents.

All pins are plain control and status signals. The register port has no handshake: a write completes in the cycle `reg_we_i` is high, and a read is a combinational decode of `reg_addr_i`. Neither the register port nor the time inputs have a valid/ready handshake, so no back-pressure exists.

Top module: `alarm_unit`

## Requirements
- R1: After reset, all four alarm fields read 0x00, the enable bit reads 0 and `alarm_irq_o` is low.
- R2: The seconds field is at address 0 and the minutes field at address 1. A write to either is stored (all 8 bits) only if the low 7 bits decode as tens×10+units (tens in bits 6:4, units in bits 3:0) to at most 59. Otherwise the field is unchanged.
- R3: The hours field is at address 2. A write is stored (all 8 bits) only if the low 6 bits decode as tens×10+units (tens in bits 5:4, units in bits 3:0) to at most 23. Otherwise the field is unchanged.
- R4: The date field is at address 3. A write is stored (all 8 bits) only if the low 6 bits decode as tens×10+units (tens in bits 5:4) to a non-zero value. Otherwise the field is unchanged.
- R5: Address 4 holds the interrupt enable in bit 0, and reads return zero in bits 7:1. Addresses 5 to 7 read 0x00, and writes to them change nothing.
- R6: With all four flags (bit 7) clear, the alarm fires only when seconds (7 bits), minutes (7 bits), hours (6 bits) and date (6 bits) all equal the time inputs.
- R7: With only the date flag set, the date is ignored, and seconds, minutes and hours must all match.
- R8: With the date and hours flags set and the others clear, only seconds and minutes must match.
- R9: With the date, hours and minutes flags set and seconds clear, only seconds must match.
- R10: Any other flag pattern fires on every tick.
- R11: `alarm_irq_o` is high for exactly the one cycle after a tick cycle in which the enable is 1 and the selected fields match. With the enable at 0, or with no tick, it stays low.
- R12: A write in the same cycle as a tick does not affect that tick's comparison. It does apply from the next tick onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for `reg_addr_i` (combinational) |
| tod_sec_i | input | 7 | Current seconds, BCD |
| tod_min_i | input | 7 | Current minutes, BCD |
| tod_hour_i | input | 6 | Current hours, BCD |
| tod_date_i | input | 6 | Current day of month, BCD |
| sec_tick_i | input | 1 | One-cycle pulse each second |
| alarm_irq_o | output | 1 | Alarm interrupt pulse |

## Verification
A register write lands at the clock edge that samples it. Its effect shows on `reg_rdata_o` right after that edge, so the bench reads back at the following falling edge. The interrupt comes from a single register: it is due in the cycle after the tick edge and falls one cycle later. The bench raises the tick on a falling edge, samples the pulse at the next falling edge and confirms it is low one falling edge after that. For the same-cycle write case, the bench expects the old field value to govern the tick that shares the write's edge.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int FIELD_CNT = 4;
  localparam int FLD_SEC   = 0;
  localparam int FLD_MIN   = 1;
  localparam int FLD_HOUR  = 2;
  localparam int FLD_DATE  = 3;
  localparam int ADR_CTRL  = 4;
  localparam int MASK_BIT  = 7;

  typedef enum logic [2:0] {
    RPT_MONTH,
    RPT_DAY,
    RPT_HOUR,
    RPT_MINUTE,
    RPT_SECOND
  } rpt_mode_e;

  // tens * 10 + units of an already-trimmed BCD byte
  function automatic int unsigned bcd_value(input logic [7:0] v);
    return 32'(v[7:4]) * 10 + 32'(v[3:0]);
  endfunction

  // compared bits of each field
  function automatic logic [7:0] field_bits(input int idx);
    return (idx < 2) ? 8'h7F : 8'h3F;
  endfunction
endpackage

// File: rtl/alarm_regs.sv
module alarm_regs
  import alarm_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           we_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [DATA_W-1:0]              wdata_i,
  output logic [DATA_W-1:0]              rdata_o,
  output logic [FIELD_CNT-1:0][DATA_W-1:0] alarm_o,
  output logic                           irq_en_o
);
  logic [FIELD_CNT-1:0][DATA_W-1:0] alarm_q;
  logic [FIELD_CNT-1:0]             wr_hit;
  logic [FIELD_CNT-1:0]             accept;
  logic                             en_q;

  always_comb begin
    for (int i = 0; i < FIELD_CNT; i++)
      wr_hit[i] = we_i && (addr_i == ADDR_W'(i));
    accept[FLD_SEC]  = bcd_value(wdata_i & 8'h7F) <= 59;
    accept[FLD_MIN]  = bcd_value(wdata_i & 8'h7F) <= 59;
    accept[FLD_HOUR] = bcd_value(wdata_i & 8'h3F) <= 23;
    accept[FLD_DATE] = bcd_value(wdata_i & 8'h3F) != 0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_q <= '0;
      en_q    <= 1'b0;
    end else begin
      for (int i = 0; i < FIELD_CNT; i++)
        if (wr_hit[i] && accept[i]) alarm_q[i] <= wdata_i;
      if (we_i && addr_i == ADDR_W'(ADR_CTRL)) en_q <= wdata_i[0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i < ADDR_W'(FIELD_CNT)) rdata_o = alarm_q[addr_i[1:0]];
    else if (addr_i == ADDR_W'(ADR_CTRL)) rdata_o = {{(DATA_W-1){1'b0}}, en_q};
  end

  assign alarm_o  = alarm_q;
  assign irq_en_o = en_q;

  p_sec_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bcd_value(alarm_q[FLD_SEC] & 8'h7F) <= 59);
  p_min_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bcd_value(alarm_q[FLD_MIN] & 8'h7F) <= 59);
  p_hour_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bcd_value(alarm_q[FLD_HOUR] & 8'h3F) <= 23);
  p_date_zero_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && addr_i == ADDR_W'(FLD_DATE) && wdata_i[5:0] == 6'd0)
      |=> $stable(alarm_q[FLD_DATE]));
  p_ctrl_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i == ADDR_W'(ADR_CTRL)) |-> (rdata_o[DATA_W-1:1] == '0));
endmodule

// File: rtl/alarm_mode_dec.sv
module alarm_mode_dec
  import alarm_pkg::*;
(
  input  logic [FIELD_CNT-1:0] flags_i,
  output rpt_mode_e            mode_o,
  output logic [FIELD_CNT-1:0] cmp_en_o
);
  // flags_i[i] is the don't-care flag of field i (date is the top index)
  always_comb begin
    unique case (flags_i)
      4'b0000: begin mode_o = RPT_MONTH;  cmp_en_o = 4'b1111; end
      4'b1000: begin mode_o = RPT_DAY;    cmp_en_o = 4'b0111; end
      4'b1100: begin mode_o = RPT_HOUR;   cmp_en_o = 4'b0011; end
      4'b1110: begin mode_o = RPT_MINUTE; cmp_en_o = 4'b0001; end
      default: begin mode_o = RPT_SECOND; cmp_en_o = 4'b0000; end
    endcase
  end
endmodule

// File: rtl/alarm_match.sv
module alarm_match
  import alarm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [FIELD_CNT-1:0][DATA_W-1:0] alarm_i,
  input  logic [FIELD_CNT-1:0][DATA_W-1:0] tod_i,
  input  logic [FIELD_CNT-1:0]             cmp_en_i,
  output logic                             hit_o
);
  logic [FIELD_CNT-1:0] eq;

  for (genvar g = 0; g < FIELD_CNT; g++) begin : g_cmp
    localparam logic [DATA_W-1:0] KEEP = DATA_W'(field_bits(g));
    assign eq[g] = (alarm_i[g] & KEEP) == (tod_i[g] & KEEP);
  end

  assign hit_o = &(~cmp_en_i | eq);
endmodule

// File: rtl/alarm_unit.sv
module alarm_unit
  import alarm_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [6:0]        tod_sec_i,
  input  logic [6:0]        tod_min_i,
  input  logic [5:0]        tod_hour_i,
  input  logic [5:0]        tod_date_i,
  input  logic              sec_tick_i,
  output logic              alarm_irq_o
);
  logic [FIELD_CNT-1:0][DATA_W-1:0] alarm_w;
  logic [FIELD_CNT-1:0][DATA_W-1:0] tod_w;
  logic [FIELD_CNT-1:0]             flags_w;
  logic [FIELD_CNT-1:0]             cmp_en_w;
  rpt_mode_e                        mode_w;
  logic                             irq_en_w;
  logic                             hit_w;
  logic                             irq_q;

  assign tod_w[FLD_SEC]  = DATA_W'(tod_sec_i);
  assign tod_w[FLD_MIN]  = DATA_W'(tod_min_i);
  assign tod_w[FLD_HOUR] = DATA_W'(tod_hour_i);
  assign tod_w[FLD_DATE] = DATA_W'(tod_date_i);

  for (genvar g = 0; g < FIELD_CNT; g++) begin : g_flag
    assign flags_w[g] = alarm_w[g][MASK_BIT];
  end

  alarm_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o), .alarm_o(alarm_w),
    .irq_en_o(irq_en_w)
  );

  alarm_mode_dec u_mode (
    .flags_i(flags_w), .mode_o(mode_w), .cmp_en_o(cmp_en_w)
  );

  alarm_match #(.DATA_W(DATA_W)) u_match (
    .alarm_i(alarm_w), .tod_i(tod_w), .cmp_en_i(cmp_en_w), .hit_o(hit_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= sec_tick_i && irq_en_w && hit_w;
  end

  assign alarm_irq_o = irq_q;

  p_pulse_needs_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_irq_o |-> $past(sec_tick_i && irq_en_w));
  p_every_second_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick_i && irq_en_w && mode_w == RPT_SECOND) |=> alarm_irq_o);
  p_month_sec_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick_i && mode_w == RPT_MONTH &&
     alarm_w[FLD_SEC][6:0] != tod_sec_i) |=> !alarm_irq_o);
endmodule

// File: tb/alarm_unit_tb.sv
module alarm_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [6:0] t_sec = '0, t_min = '0;
  logic [5:0] t_hour = '0, t_date = '0;
  logic       tick = 1'b0;
  logic       irq;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  alarm_unit u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .tod_sec_i(t_sec),
    .tod_min_i(t_min), .tod_hour_i(t_hour), .tod_date_i(t_date),
    .sec_tick_i(tick), .alarm_irq_o(irq)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp, input string tag);
    addr = a; #1;
    check(rdata == exp, tag, rdata, exp);
  endtask

  task automatic set_tod(input logic [7:0] s, input logic [7:0] m,
                         input logic [7:0] h, input logic [7:0] d);
    t_sec = s[6:0]; t_min = m[6:0]; t_hour = h[5:0]; t_date = d[5:0];
  endtask

  task automatic tick_chk(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                          input logic [7:0] d, input bit exp, input string tag);
    @(negedge clk); set_tod(s, m, h, d); tick = 1'b1;
    @(negedge clk); tick = 1'b0; #1;
    check(irq == exp, tag, irq, exp);
    @(negedge clk); #1;
    check(irq == 1'b0, {tag, " pulse end"}, irq, 0);
  endtask

  function automatic bit accept_of(input int f, input int v);
    int tens, units, val;
    units = v & 15;
    tens  = (f < 2) ? ((v >> 4) & 7) : ((v >> 4) & 3);
    val   = tens * 10 + units;
    if (f < 2)  return val <= 59;
    if (f == 2) return val <= 23;
    return val != 0;
  endfunction

  function automatic logic [3:0] cmp_set(input logic [3:0] p);
    case (p)
      4'b0000: return 4'b1111;
      4'b1000: return 4'b0111;
      4'b1100: return 4'b0011;
      4'b1110: return 4'b0001;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic string mode_tag(input logic [3:0] p);
    case (p)
      4'b0000: return "R6 monthly";
      4'b1000: return "R7 daily";
      4'b1100: return "R8 hourly";
      4'b1110: return "R9 minute";
      default: return "R10 every second";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] model [4];
    logic [7:0] base [4];
    base[0] = 8'h30; base[1] = 8'h45; base[2] = 8'h12; base[3] = 8'h15;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 5; a++) rd_chk(3'(a), 8'h00, "R1 reset register");
    check(irq == 1'b0, "R1 reset irq", irq, 0);

    // R5 control register and unused addresses
    wr(3'd4, 8'hFF);
    rd_chk(3'd4, 8'h01, "R5 enable set");
    wr(3'd4, 8'hFE);
    rd_chk(3'd4, 8'h00, "R5 enable cleared by bit0");
    for (int a = 5; a < 8; a++) begin
      wr(3'(a), 8'hA5);
      rd_chk(3'(a), 8'h00, "R5 unused address");
    end
    for (int a = 0; a < 5; a++) rd_chk(3'(a), 8'h00, "R5 unused write no effect");

    // R2 R3 R4 exhaustive write sweep per field
    for (int f = 0; f < 4; f++) begin
      model[f] = 8'h00;
      for (int v = 0; v < 256; v++) begin
        if (accept_of(f, v)) model[f] = 8'(v);
        wr(3'(f), 8'(v));
        rd_chk(3'(f), model[f], (f < 2) ? "R2 sec/min write filter" :
                                (f == 2) ? "R3 hour write filter" : "R4 date write filter");
      end
    end

    // R11 enable off: no pulse even on full match
    for (int f = 0; f < 4; f++) wr(3'(f), base[f]);
    tick_chk(base[0], base[1], base[2], base[3], 1'b0, "R11 disabled no pulse");
    wr(3'd4, 8'h01);
    // R11 match without tick: no pulse
    @(negedge clk); set_tod(base[0], base[1], base[2], base[3]);
    @(negedge clk); #1;
    check(irq == 1'b0, "R11 no tick no pulse", irq, 0);

    // R6..R10 sweep over all 16 flag patterns
    for (int p = 0; p < 16; p++) begin
      logic [3:0] cs;
      cs = cmp_set(4'(p));
      for (int f = 0; f < 4; f++) wr(3'(f), base[f] | (((p >> f) & 1) ? 8'h80 : 8'h00));
      tick_chk(base[0], base[1], base[2], base[3], 1'b1, {mode_tag(4'(p)), " full match"});
      for (int d = 0; d < 4; d++) begin
        logic [7:0] tv [4];
        for (int f = 0; f < 4; f++) tv[f] = base[f];
        tv[d] = base[d] + 8'h01;
        tick_chk(tv[0], tv[1], tv[2], tv[3], !cs[d], {mode_tag(4'(p)), " one field off"});
      end
    end

    // R12 write coinciding with tick uses old value
    for (int f = 0; f < 4; f++) wr(3'(f), base[f]);
    @(negedge clk);
    set_tod(base[0], base[1], base[2], base[3]);
    we = 1'b1; addr = 3'd0; wdata = 8'h31; tick = 1'b1;
    @(negedge clk); we = 1'b0; tick = 1'b0; #1;
    check(irq == 1'b1, "R12 same-cycle write uses old value", irq, 1);
    tick_chk(base[0], base[1], base[2], base[3], 1'b0, "R12 old value gone");
    tick_chk(8'h31, base[1], base[2], base[3], 1'b1, "R12 new value used");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule